// File: doc/BRIEF.md
# Control Endpoint Handshake Responder

This block keeps the configuration and status word of a USB device's default control endpoint and picks the handshake for each transaction addressed to it. Software reaches the word through a plain read/write port. With that port it turns the endpoint on, requests stall or NAK on each direction, suppresses the OUT handshake, and programs the maximum packet size.

The serial interface engine sends a one-cycle pulse for each decoded token, together with its kind, and raises a busy flag while a transfer is under way. One clock after each accepted token the block returns a response code. A SETUP token clears both stall requests in hardware. A stall stays in force until that SETUP token arrives. The maximum packet size is held steady while a transfer is busy.

Top module: `ctrl_ep_responder`

## Requirements
- R1: After reset the read-back word is 0, respValid is 0 and maxPkt is 0.
- R2: While the enable bit (bit 31) is 0, tokens give no response and a SETUP token does not clear the stall bits.
- R3: An accepted token (tokKind 0 = SETUP, 1 = OUT, 2 = IN) on an enabled endpoint raises respValid for exactly one cycle, one clock after the token. tokKind 3 gives no response.
- R4: For an IN token the response is STALL if the IN-stall bit (bit 20) is set. Otherwise it is NAK if the IN-NAK bit (bit 19) is set. Otherwise it is ACK/data. The no-handshake bit has no effect on IN. Codes: 0 = ACK/data, 1 = NAK, 2 = STALL, 3 = none.
- R5: For an OUT token the response is checked in this order: STALL if the OUT-stall bit (bit 18) is set, then NAK if the OUT-NAK bit (bit 16) is set, then none (code 3) if the no-handshake bit (bit 17) is set, and ACK otherwise.
- R6: A SETUP token on an enabled endpoint is answered with ACK whatever the other bits hold. It clears bits 20 and 18, even when a write in the same cycle sets them.
- R7: A stall bit can be set by software but not cleared by it. Once set, it stays set and every later token of that direction gets STALL until a SETUP token arrives.
- R8: A write while xferBusy is 1 leaves the max packet size (bits 6:0) unchanged, but it still updates the other fields.
- R9: Reserved bits (30:21 and 15:7) read back as 0 whatever value is written to them.
- R10: The maxPkt output always equals bits 6:0 of the read-back word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read-back word |
| tokValid | input | 1 | One-cycle token pulse from the serial engine |
| tokKind | input | 2 | Token kind: 0 SETUP, 1 OUT, 2 IN, 3 reserved |
| xferBusy | input | 1 | Transfer in progress; locks the max packet size |
| respValid | output | 1 | Response code valid, one cycle after the token |
| respCode | output | 2 | 0 ACK/data, 1 NAK, 2 STALL, 3 no handshake |
| maxPkt | output | 7 | Current max packet size |

## Verification
A stall bit that fails to stick, or that a SETUP token fails to clear, shows up as a wrong response code on the very next token of that direction, one clock after the token. A fault in the priority order shows up the same way when several control bits are set together. A register fault shows up at once on regRdData or maxPkt in the cycle after the write. A disabled endpoint that leaks a response shows up as a respValid pulse when none is expected.

// File: rtl/ctrl_ep_pkg.sv
package ctrl_ep_pkg;
  typedef enum logic [1:0] {
    TOK_SETUP = 2'd0,
    TOK_OUT   = 2'd1,
    TOK_IN    = 2'd2,
    TOK_RSVD  = 2'd3
  } tokKind_e;

  typedef enum logic [1:0] {
    RSP_ACK   = 2'd0,
    RSP_NAK   = 2'd1,
    RSP_STALL = 2'd2,
    RSP_NONE  = 2'd3
  } respCode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrStall;
  } epStrobe_t;

  localparam int EN_BIT       = 31;
  localparam int IN_STALL_BIT = 20;
  localparam int IN_NAK_BIT   = 19;
  localparam int OUT_STALL_BIT = 18;
  localparam int NO_HSK_BIT   = 17;
  localparam int OUT_NAK_BIT  = 16;
endpackage

// File: rtl/ctrlEpRegs.sv
module ctrlEpRegs
  import ctrl_ep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAXP_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              busy,
  input  epStrobe_t         strobe,
  output logic              en,
  output logic              inStall,
  output logic              inNak,
  output logic              outStall,
  output logic              noHsk,
  output logic              outNak,
  output logic [MAXP_W-1:0] maxp,
  output logic [DATA_W-1:0] rdData
);
  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      en       <= 1'b0;
      inStall  <= 1'b0;
      inNak    <= 1'b0;
      outStall <= 1'b0;
      noHsk    <= 1'b0;
      outNak   <= 1'b0;
      maxp     <= '0;
    end else begin
      if (wrEn) begin
        en     <= wrData[EN_BIT];
        inNak  <= wrData[IN_NAK_BIT];
        noHsk  <= wrData[NO_HSK_BIT];
        outNak <= wrData[OUT_NAK_BIT];
        if (!busy) maxp <= wrData[MAXP_W-1:0];
      end
      // stall bits: software may only set; a SETUP clears, winning over a write
      inStall  <= (inStall  | (wrEn & wrData[IN_STALL_BIT]))  & ~strobe.clrStall;
      outStall <= (outStall | (wrEn & wrData[OUT_STALL_BIT])) & ~strobe.clrStall;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[EN_BIT]        = en;
    rdData[IN_STALL_BIT]  = inStall;
    rdData[IN_NAK_BIT]    = inNak;
    rdData[OUT_STALL_BIT] = outStall;
    rdData[NO_HSK_BIT]    = noHsk;
    rdData[OUT_NAK_BIT]   = outNak;
    rdData[MAXP_W-1:0]    = maxp;
  end

  AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.clrStall) |-> (!inStall && !outStall)); // R6

  AST_MAXP_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) && $past(rstN) |-> $stable(maxp)); // R8

  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    $past(inStall) && !$past(strobe.clrStall) && $past(rstN) |-> inStall); // R7
endmodule

// File: rtl/ctrlEpDecide.sv
module ctrlEpDecide
  import ctrl_ep_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tokValid,
  input  tokKind_e  tokKind,
  input  logic      en,
  input  logic      inStall,
  input  logic      inNak,
  input  logic      outStall,
  input  logic      noHsk,
  input  logic      outNak,
  output epStrobe_t strobe,
  output logic      respValid,
  output respCode_e respCode
);
  logic      accept;
  respCode_e nextCode;

  assign accept = tokValid && en && (tokKind != TOK_RSVD);

  always_comb begin
    strobe          = '0;
    strobe.clrStall = accept && (tokKind == TOK_SETUP);
  end

  always_comb begin
    nextCode = RSP_ACK;
    unique case (tokKind)
      TOK_IN: begin
        if (inStall)    nextCode = RSP_STALL;
        else if (inNak) nextCode = RSP_NAK;
        else            nextCode = RSP_ACK;
      end
      TOK_OUT: begin
        if (outStall)     nextCode = RSP_STALL;
        else if (outNak)  nextCode = RSP_NAK;
        else if (noHsk)   nextCode = RSP_NONE;
        else              nextCode = RSP_ACK;
      end
      default: nextCode = RSP_ACK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respCode  <= RSP_ACK;
    end else begin
      respValid <= accept;
      respCode  <= nextCode;
    end
  end

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $past(tokValid && !en) && $past(rstN) |-> !respValid); // R2

  AST_SETUP_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    $past(tokValid && en && tokKind == TOK_SETUP) && $past(rstN)
      |-> (respValid && respCode == RSP_ACK)); // R6

  AST_IN_STALL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(tokValid && en && tokKind == TOK_IN && inStall) && $past(rstN)
      |-> (respCode == RSP_STALL)); // R4

  AST_OUT_STALL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(tokValid && en && tokKind == TOK_OUT && outStall) && $past(rstN)
      |-> (respCode == RSP_STALL)); // R5

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !tokValid |=> !respValid); // R3
endmodule

// File: rtl/ctrl_ep_responder.sv
module ctrl_ep_responder
  import ctrl_ep_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MAXP_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tokValid,
  input  logic [1:0]        tokKind,
  input  logic              xferBusy,
  output logic              respValid,
  output logic [1:0]        respCode,
  output logic [MAXP_W-1:0] maxPkt
);
  epStrobe_t strobe;
  respCode_e code;
  logic en, inStall, inNak, outStall, noHsk, outNak;

  ctrlEpRegs #(.DATA_W(DATA_W), .MAXP_W(MAXP_W)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrData(regWrData),
    .busy(xferBusy), .strobe(strobe),
    .en(en), .inStall(inStall), .inNak(inNak), .outStall(outStall),
    .noHsk(noHsk), .outNak(outNak), .maxp(maxPkt), .rdData(regRdData)
  );

  ctrlEpDecide uDecide (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokKind(tokKind_e'(tokKind)),
    .en(en), .inStall(inStall), .inNak(inNak), .outStall(outStall),
    .noHsk(noHsk), .outNak(outNak),
    .strobe(strobe), .respValid(respValid), .respCode(code)
  );

  assign respCode = code;

  AST_MAXP_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    maxPkt == regRdData[MAXP_W-1:0]); // R10
endmodule

// File: tb/sim_ctrl_ep_responder.sv
`timescale 1ns/100ps
module sim_ctrl_ep_responder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic tokValid = 1'b0;
  logic [1:0] tokKind = 2'd0;
  logic xferBusy = 1'b0;
  logic respValid;
  logic [1:0] respCode;
  logic [6:0] maxPkt;

  int compared = 0;
  int mismatched = 0;
  logic [1:0] expQ[$];
  string tagQ[$];

  // bench model of the register
  logic mEn, mInSt, mInNak, mOutSt, mNoHsk, mOutNak;
  logic [6:0] mMaxp;

  always #2.5 clk = ~clk;

  ctrl_ep_responder u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .tokValid(tokValid), .tokKind(tokKind),
    .xferBusy(xferBusy), .respValid(respValid), .respCode(respCode),
    .maxPkt(maxPkt)
  );

  function automatic logic [31:0] modelWord();
    logic [31:0] w = '0;
    w[31] = mEn; w[20] = mInSt; w[19] = mInNak;
    w[18] = mOutSt; w[17] = mNoHsk; w[16] = mOutNak;
    w[6:0] = mMaxp;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle of stimulus: optional write and optional token, model updated
  task automatic step(input logic doWr, input logic [31:0] d, input logic busy,
                      input logic doTok, input logic [1:0] kind, input string tag);
    logic [1:0] e;
    regWrEn = doWr; regWrData = d; xferBusy = busy;
    tokValid = doTok; tokKind = kind;
    if (doTok && mEn && kind != 2'd3) begin
      case (kind)
        2'd2: e = mInSt ? 2'd2 : (mInNak ? 2'd1 : 2'd0);
        2'd1: e = mOutSt ? 2'd2 : (mOutNak ? 2'd1 : (mNoHsk ? 2'd3 : 2'd0));
        default: e = 2'd0;
      endcase
      expQ.push_back(e); tagQ.push_back(tag);
    end
    if (doWr) begin
      mEn = d[31]; mInNak = d[19]; mNoHsk = d[17]; mOutNak = d[16];
      mInSt = mInSt | d[20]; mOutSt = mOutSt | d[18];
      if (!busy) mMaxp = d[6:0];
    end
    if (doTok && mEn && kind == 2'd0 && !(doWr && !d[31])) begin
      mInSt = 1'b0; mOutSt = 1'b0;
    end
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; xferBusy = 1'b0; tokValid = 1'b0; tokKind = 2'd0;
  endtask

  task automatic wr(input logic [31:0] d, input logic busy, input string tag);
    step(1'b1, d, busy, 1'b0, 2'd0, tag);
    check({tag, " readback"}, regRdData, modelWord());
    check({tag, " maxPkt R10"}, {25'd0, maxPkt}, {25'd0, mMaxp});
  endtask

  task automatic tok(input logic [1:0] kind, input string tag);
    step(1'b0, '0, 1'b0, 1'b1, kind, tag);
  endtask

  // monitor: pops expected responses as they appear
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (expQ.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R2/R3 unexpected response actual=%0d expected=none", respCode);
      end else begin
        automatic logic [1:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, {30'd0, respCode}, {30'd0, e});
      end
    end
  end

  initial begin
    #50000;
    compared++; mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    {mEn, mInSt, mInNak, mOutSt, mNoHsk, mOutNak} = '0;
    mMaxp = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset readback", regRdData, 32'd0);
    check("R1 reset respValid", {31'd0, respValid}, 32'd0);
    check("R1 reset maxPkt", {25'd0, maxPkt}, 32'd0);

    // disabled endpoint: set IN stall, then tokens are ignored
    wr(32'h0010_0000, 1'b0, "R2 stall while disabled");
    tok(2'd0, "R2 setup disabled");
    tok(2'd2, "R2 in disabled");
    @(negedge clk);
    check("R2 no response when disabled", {31'd0, respValid}, 32'd0);
    check("R2 stall survives disabled setup", regRdData, modelWord());

    // enable, max packet 64
    wr(32'h8000_0040, 1'b0, "R10 enable maxp 64");
    tok(2'd2, "R4 R7 in stalled");
    tok(2'd1, "R5 out ack");
    wr(32'h8000_0040, 1'b0, "R7 software clear attempt");
    check("R7 in stall kept", {31'd0, regRdData[20]}, 32'd1);
    tok(2'd2, "R7 in still stalled");

    // SETUP clears stall
    tok(2'd0, "R6 setup ack");
    @(negedge clk);
    check("R6 stalls cleared", regRdData, modelWord());
    tok(2'd2, "R4 in data");
    wr(32'h8008_0040, 1'b0, "R4 set in nak");
    tok(2'd2, "R4 in nak");
    wr(32'h8018_0040, 1'b0, "R4 set in stall+nak");
    tok(2'd2, "R4 stall beats nak");
    tok(2'd0, "R6 setup with stall set");

    // SETUP in same cycle as write setting OUT stall
    step(1'b1, 32'h8004_0040, 1'b0, 1'b1, 2'd0, "R6 setup vs write");
    check("R6 same-cycle clear", regRdData, modelWord());
    tok(2'd1, "R6 out ack after setup");

    // OUT priority
    wr(32'h8001_0040, 1'b0, "R5 out nak");
    tok(2'd1, "R5 out nak");
    wr(32'h8002_0040, 1'b0, "R5 no handshake");
    tok(2'd1, "R5 out none");
    tok(2'd2, "R4 in ignores no handshake");
    wr(32'h8003_0040, 1'b0, "R5 nak+nohsk");
    tok(2'd1, "R5 nak beats none");
    wr(32'h8007_0040, 1'b0, "R5 all out bits");
    tok(2'd1, "R5 stall beats all");
    tok(2'd1, "R7 out stays stalled");
    tok(2'd0, "R6 setup clears out");

    // back-to-back tokens
    tok(2'd1, "R3 b2b 1");
    tok(2'd2, "R3 b2b 2");
    tok(2'd3, "R3 reserved kind");
    @(negedge clk);
    check("R3 reserved kind silent", {31'd0, respValid}, 32'd0);

    // max packet lock
    wr(32'h8008_0008, 1'b1, "R8 busy write");
    check("R8 maxp held", {25'd0, maxPkt}, 32'd64);
    check("R8 nak taken", {31'd0, regRdData[19]}, 32'd1);
    wr(32'h8000_0008, 1'b0, "R8 idle write");
    check("R8 maxp updated", {25'd0, maxPkt}, 32'd8);

    // reserved bits
    wr(32'hFFFF_FFFF, 1'b0, "R9 reserved");
    check("R9 reserved zero", regRdData & 32'h7FE0_FF80, 32'd0);

    repeat (3) @(negedge clk);
    check("R3 all responses seen", expQ.size(), 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule